// File: doc/BRIEF.md
# Display Control Register With Protected Fields

This block implements a display configuration register that sits on a shared 32-bit register bus beside many other registers. On a write, a build-time mask decides which bits keep their current contents. All other bits load the write data. The block is built in one of four variants:

- a mux-steering variant, with bits 13:8 protected;
- a plain variant, with the same protection and no steering output;
- a narrow variant, with only bit 7 protected;
- an absent variant, with no display register.

In the mux-steering variant, every write to the display register also loads a registered two-bit select output. That output steers an external display-source multiplexer.

The same block also provides a read-only card-status word. This word shows two card-status input lines after a two-flop synchroniser. Reads of the display register and the status word are combinational from the address. All other addresses read as zero. The bus master, the multiplexer, the display controller and the card slot are outside the block.

Top module: `dispctl_reg`

## Requirements
- R1: After reset the display register reads 0x00001F00 in the mux-steering, plain and narrow variants and 0 in the absent variant. The select output is 0 and the card-status word reads 0.
- R2: In the mux-steering and plain variants, a write to byte offset 0x50 leaves bits 13:8 unchanged and loads every other bit from the write data. The new value is (old & 0x3F00) | (data & ~0x3F00).
- R3: In the narrow variant, a write to 0x50 keeps only bit 7 and loads every other bit from the write data.
- R4: In the absent variant, offset 0x50 always reads 0 and writes to it have no effect.
- R5: In the mux-steering variant, each write to 0x50 sets the select output to bits 1:0 of the write data from the next clock edge. It holds that value until the next write to 0x50. In the other variants the select output stays 0.
- R6: The card-status word at byte offset 0x48 shows the card-inserted line in bit 0. It shows the write-protect line in bit 4 for the mux-steering and plain variants and in bit 2 for the narrow and absent variants. All other bits read 0.
- R7: A change on a card-status line appears in the status word after exactly two rising clock edges, and not after one.
- R8: Writes to 0x48 or to any other offset change neither register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| busAddr | input | 12 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| cardIn | input | 1 | Card-inserted line, asynchronous |
| cardWp | input | 1 | Write-protect line, asynchronous |
| muxSel | output | 2 | Display-source multiplexer select |

## Verification
The bench builds all four variants side by side and applies the same bus traffic to each.

It writes every walking-one pattern and several dense patterns to the display register. This catches a design that uses the wrong protected mask or lets the protected bits drift. A design that uses the wrong reset value would leave 0x1F00 missing from, or stuck in, the readback. The sweep also catches a select output that ignores writes or leaks into the other variants.

Writes to the status offset and to an unmapped offset expose a decoder that aliases addresses. The card lines are toggled and the status word is sampled after one edge and after two. A design with too few synchroniser stages, or with the write-protect bit at the wrong position, fails those samples.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    DC_MUXED  = 2'd0,
    DC_PLAIN  = 2'd1,
    DC_NARROW = 2'd2,
    DC_ABSENT = 2'd3
  } dcVariantE;

  typedef struct packed {
    logic selDisp;
    logic selStat;
    logic wrDisp;
  } dcStrobeT;

  function automatic logic [REG_W-1:0] protMask(dcVariantE v);
    case (v)
      DC_MUXED, DC_PLAIN: return 32'h0000_3F00;
      DC_NARROW:          return 32'h0000_0080;
      default:            return '1;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] resetVal(dcVariantE v);
    return (v == DC_ABSENT) ? '0 : 32'h0000_1F00;
  endfunction

  function automatic int wpPos(dcVariantE v);
    return (v == DC_MUXED || v == DC_PLAIN) ? 4 : 2;
  endfunction
endpackage

// File: rtl/dispctl_ctrl.sv
module dispctl_ctrl
  import dispctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int unsigned DISP_OFS = 32'h50,
  parameter int unsigned STAT_OFS = 32'h48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output dcStrobeT          strobe
);
  localparam logic [ADDR_W-1:0] DISP_A = ADDR_W'(DISP_OFS);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

  always_comb begin
    strobe.selDisp = (busAddr == DISP_A);
    strobe.selStat = (busAddr == STAT_A);
    strobe.wrDisp  = busWrEn && (busAddr == DISP_A);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selDisp, strobe.selStat})); // R8
endmodule

// File: rtl/dispctl_datapath.sv
module dispctl_datapath
  import dispctl_pkg::*;
#(
  parameter dcVariantE VARIANT = DC_MUXED,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dcStrobeT         strobe,
  input  logic [REG_W-1:0] busWrData,
  input  logic             cardIn,
  input  logic             cardWp,
  output logic [REG_W-1:0] dispVal,
  output logic [REG_W-1:0] statVal,
  output logic [SEL_W-1:0] muxSel
);
  localparam logic [REG_W-1:0] PROT = protMask(VARIANT);
  localparam logic [REG_W-1:0] RST  = resetVal(VARIANT);
  localparam int WP_POS = wpPos(VARIANT);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cinPipe;
  logic [SYNC_STAGES-1:0] wpPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cinPipe <= '0;
      wpPipe  <= '0;
    end else begin
      cinPipe <= {cinPipe[SYNC_STAGES-2:0], cardIn};
      wpPipe  <= {wpPipe[SYNC_STAGES-2:0], cardWp};
    end
  end

  always_comb begin
    statVal         = '0;
    statVal[0]      = cinPipe[LAST];
    statVal[WP_POS] = wpPipe[LAST];
  end

  generate
    if (VARIANT == DC_ABSENT) begin : g_noDisp
      assign dispVal = '0;
    end else begin : g_disp
      logic [REG_W-1:0] dispReg;
      always_ff @(posedge clk) begin
        if (!rstN) dispReg <= RST;
        else if (strobe.wrDisp) dispReg <= (dispReg & PROT) | (busWrData & ~PROT);
      end
      assign dispVal = dispReg;

      AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrDisp |=> ((dispReg & PROT) == ($past(dispReg) & PROT))); // R2
    end

    if (VARIANT == DC_MUXED) begin : g_mux
      logic [SEL_W-1:0] muxReg;
      always_ff @(posedge clk) begin
        if (!rstN) muxReg <= '0;
        else if (strobe.wrDisp) muxReg <= busWrData[SEL_W-1:0];
      end
      assign muxSel = muxReg;

      AST_MUX_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
        strobe.wrDisp |=> (muxSel == $past(busWrData[SEL_W-1:0]))); // R5
      AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.wrDisp |=> $stable(muxSel)); // R5
    end else begin : g_noMux
      assign muxSel = '0;
    end
  endgenerate
endmodule

// File: rtl/dispctl_reg.sv
module dispctl_reg
  import dispctl_pkg::*;
#(
  parameter dcVariantE VARIANT = DC_MUXED,
  parameter int ADDR_W = 12,
  parameter int unsigned DISP_OFS = 32'h50,
  parameter int unsigned STAT_OFS = 32'h48,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              cardIn,
  input  logic              cardWp,
  output logic [SEL_W-1:0]  muxSel
);
  localparam logic [REG_W-1:0] STAT_BITS = (REG_W'(1) << wpPos(VARIANT)) | REG_W'(1);

  dcStrobeT         strobe;
  logic [REG_W-1:0] dispVal;
  logic [REG_W-1:0] statVal;

  dispctl_ctrl #(.ADDR_W(ADDR_W), .DISP_OFS(DISP_OFS), .STAT_OFS(STAT_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  dispctl_datapath #(.VARIANT(VARIANT), .SYNC_STAGES(SYNC_STAGES), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .cardIn(cardIn), .cardWp(cardWp), .dispVal(dispVal), .statVal(statVal), .muxSel(muxSel)
  );

  always_comb begin
    if (strobe.selDisp)      busRdData = dispVal;
    else if (strobe.selStat) busRdData = statVal;
    else                     busRdData = '0;
  end

  AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selStat |-> ((busRdData & ~STAT_BITS) == '0)); // R6

  generate
    if (VARIANT == DC_ABSENT) begin : g_absentChk
      AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        strobe.selDisp |-> (busRdData == '0)); // R4
    end
  endgenerate
endmodule

// File: tb/dispctl_reg_test.sv
`timescale 1ns/1ps
module dispctl_reg_test;
  import dispctl_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        cardIn = 1'b0;
  logic        cardWp = 1'b0;
  logic [31:0] rd [4];
  logic [1:0]  ms [4];

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  logic [31:0] expD [4];
  logic [31:0] prot [4];
  int          wpAt [4];
  logic [1:0]  expSel;

  always #2 clk = ~clk;

  dispctl_reg #(.VARIANT(DC_MUXED)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd[0]), .cardIn(cardIn), .cardWp(cardWp), .muxSel(ms[0]));
  dispctl_reg #(.VARIANT(DC_PLAIN)) uutPlain (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd[1]), .cardIn(cardIn), .cardWp(cardWp), .muxSel(ms[1]));
  dispctl_reg #(.VARIANT(DC_NARROW)) uutNarrow (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd[2]), .cardIn(cardIn), .cardWp(cardWp), .muxSel(ms[2]));
  dispctl_reg #(.VARIANT(DC_ABSENT)) uutAbsent (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(rd[3]), .cardIn(cardIn), .cardWp(cardWp), .muxSel(ms[3]));

  task automatic check(input string req, input int v, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s variant %0d: actual %h expected %h", req, v, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic setAddr(input logic [11:0] a);
    busAddr = a;
    #1;
  endtask

  function automatic logic [31:0] expStat(input int v, input logic ci, input logic wp);
    logic [31:0] r;
    r = '0;
    r[0] = ci;
    r[wpAt[v]] = wp;
    return r;
  endfunction

  task automatic checkDisp(input string req);
    setAddr(12'h050);
    for (int v = 0; v < 4; v++) begin
      check(req, v, rd[v], expD[v]);
      check("R5", v, 32'(ms[v]), (v == 0) ? 32'(expSel) : 32'h0);
    end
  endtask

  task automatic applyDisp(input logic [31:0] d);
    busWrite(12'h050, d);
    for (int v = 0; v < 4; v++) expD[v] = (expD[v] & prot[v]) | (d & ~prot[v]);
    expSel = d[1:0];
  endtask

  initial begin
    prot[0] = 32'h3F00; prot[1] = 32'h3F00; prot[2] = 32'h0080; prot[3] = 32'hFFFF_FFFF;
    wpAt[0] = 4; wpAt[1] = 4; wpAt[2] = 2; wpAt[3] = 2;
    expD[0] = 32'h1F00; expD[1] = 32'h1F00; expD[2] = 32'h1F00; expD[3] = 32'h0;
    expSel = 2'b00;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    checkDisp("R1");
    setAddr(12'h048);
    for (int v = 0; v < 4; v++) check("R1", v, rd[v], 32'h0);

    // R2 R3 R4 R5: walking ones then dense patterns
    for (int i = 0; i < 32; i++) begin
      applyDisp(32'h1 << i);
      checkDisp(i < 16 ? "R2" : "R3");
    end
    for (int i = 0; i < 8; i++) begin
      logic [31:0] pat;
      pat = (i == 0) ? 32'hFFFF_FFFF : (i == 1) ? 32'h0 : (i == 2) ? 32'hA5A5_A5A5 :
            (i == 3) ? 32'h5A5A_5A5A : 32'(i) * 32'h9E37_79B9;
      applyDisp(pat);
      checkDisp("R4");
    end

    // R8: writes elsewhere leave both registers and select alone
    applyDisp(32'h0000_C0DE);
    busWrite(12'h048, 32'hFFFF_FFFF);
    busWrite(12'h054, 32'hFFFF_FFFF);
    busWrite(12'h04C, 32'h1234_5678);
    checkDisp("R8");
    setAddr(12'h048);
    for (int v = 0; v < 4; v++) check("R8", v, rd[v], 32'h0);
    setAddr(12'h054);
    for (int v = 0; v < 4; v++) check("R8", v, rd[v], 32'h0);

    // R6 R7: card-status sweep through the synchroniser
    for (int k = 1; k < 8; k++) begin
      logic ci;
      logic wp;
      logic pci;
      logic pwp;
      pci = cardIn; pwp = cardWp;
      ci = k[0] ^ k[2]; wp = k[1];
      @(negedge clk);
      cardIn = ci; cardWp = wp;
      setAddr(12'h048);
      @(negedge clk);
      #1;
      for (int v = 0; v < 4; v++) check("R7", v, rd[v], expStat(v, pci, pwp));
      @(negedge clk);
      #1;
      for (int v = 0; v < 4; v++) check("R6", v, rd[v], expStat(v, ci, wp));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule